// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a serial audio stream made of a bit clock, a frame clock and one data line, and turns it into parallel two's-complement samples, each tagged with a channel index. It decodes four two-channel framings (I2S, left-justified, right-justified and a pulse-framed DSP style) and two packed framings that carry eight channels on one data line. A 3-bit code selects the framing and a 2-bit code selects a 16, 20 or 24-bit word. Both codes are static and change only while reset is held.

The block is always a slave, so all three serial lines are inputs. They are oversampled by a faster system clock, passed through synchronizers, and acted on only at rising edges of the bit clock. A single position counter, cleared at every qualifying frame-clock transition, places each word in its framing. Every finished word comes out as a 24-bit left-aligned sample with a one-cycle valid strobe and its channel index.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is high and in the cycle after it, `smp_valid` is 0, `smp_data` is zero and `smp_chan` is zero.
- R2: Format code 000 (I2S): the serial lines are sampled at bit-clock rising edges. The first sample after a frame-clock transition is position 0, and the MSB is at position 1. A word is channel 0 when the frame clock is low and channel 1 when it is high.
- R3: Format code 011 (left-justified): the MSB is at position 0. Channels are tagged as in R2.
- R4: Format code 001 (right-justified): each half-frame lasts 32 bit clocks. The LSB is at position 31 and the MSB is at position 32 minus the word width. Channels are tagged as in R2.
- R5: Format code 010 (DSP): only a low-to-high frame-clock transition starts a frame. Channel 0 occupies positions 1 to W and channel 1 occupies positions W+1 to 2W, where W is the word width.
- R6: Format code 100 (packed, 256 clocks per frame): each frame-clock half holds four 32-clock slots. The MSB is at the first clock of a slot. The channel index is 4 × (frame-clock level) + slot number, which gives the order 0 to 7 over the frame.
- R7: Format code 101 (packed, 128 clocks per frame): the same as R6 but with 16-clock slots. The word width is always 16 bits, whatever the width code.
- R8: Width code 00 selects 24 bits, 01 selects 20 bits and 10 selects 16 bits. The output is left-aligned with zero-filled low bits. Data bits outside a word's window have no effect on any output. Positive full scale 7FFFFF and negative full scale 800000 pass through unchanged at 24 bits.
- R9: Format codes 110 and 111 behave exactly as 000. Width code 11 behaves as 00.
- R10: `smp_valid` is high for exactly one cycle per word, together with that word's data and channel. No word is produced before the first qualifying frame-clock transition after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Framing code (static) |
| width_sel | input | 2 | Word width code (static) |
| ser_bclk | input | 1 | Serial bit clock |
| ser_fclk | input | 1 | Serial frame clock |
| ser_data | input | 1 | Serial data, MSB first |
| smp_valid | output | 1 | One-cycle strobe for a finished word |
| smp_data | output | 24 | Left-aligned two's-complement sample |
| smp_chan | output | 3 | Channel index of the sample |

## Verification
The assertions assume that each high phase and each low phase of the bit clock lasts at least two system clocks, so that successive words are always at least two cycles apart. They also assume that both configuration codes stay constant outside reset. The stimulus meets both assumptions: it holds each bit-clock phase for exactly two system clocks, and it changes the framing and width codes only while reset is held. It then sweeps all 32 code combinations, filling bit positions outside each word's window with random data.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_RJ    = 3'd1,
    FMT_DSP   = 3'd2,
    FMT_LJ    = 3'd3,
    FMT_PK256 = 3'd4,
    FMT_PK128 = 3'd5
  } fmt_e;

  localparam int WIDTH_24 = 24;
  localparam int WIDTH_20 = 20;
  localparam int WIDTH_16 = 16;

  // Reserved codes fall back to I2S.
  function automatic fmt_e decode_fmt(input logic [2:0] code);
    fmt_e f;
    case (code)
      3'd1:    f = FMT_RJ;
      3'd2:    f = FMT_DSP;
      3'd3:    f = FMT_LJ;
      3'd4:    f = FMT_PK256;
      3'd5:    f = FMT_PK128;
      default: f = FMT_I2S;
    endcase
    return f;
  endfunction

  // Reserved code falls back to the widest word.
  function automatic int width_of(input logic [1:0] code);
    int w;
    case (code)
      2'b01:   w = WIDTH_20;
      2'b10:   w = WIDTH_16;
      default: w = WIDTH_24;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sar_line_sync.sv
module sar_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic data_in,
  output logic bclk_rise,
  output logic fclk_s,
  output logic data_s
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] line_in;
  logic [NLINES-1:0] line_out;
  logic              bclk_prev;

  assign line_in = {data_in, fclk_in, bclk_in};

  // All three lines see the same delay so they stay aligned.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_out[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) bclk_prev <= 1'b0;
    else     bclk_prev <= line_out[0];
  end

  assign bclk_rise = line_out[0] & ~bclk_prev;
  assign fclk_s    = line_out[1];
  assign data_s    = line_out[2];
endmodule

// File: rtl/sar_frame_track.sv
module sar_frame_track #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_rise,
  input  logic             fclk_s,
  input  logic             data_s,
  input  logic             rise_only,
  output logic             bit_stb,
  output logic             bit_val,
  output logic [POS_W-1:0] pos,
  output logic             half,
  output logic             locked
);
  logic primed;
  logic fclk_prev;
  logic frame_edge;

  assign frame_edge = rise_only ? (fclk_s & ~fclk_prev) : (fclk_s ^ fclk_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      fclk_prev <= 1'b0;
      bit_stb   <= 1'b0;
      bit_val   <= 1'b0;
      pos       <= '0;
      half      <= 1'b0;
      locked    <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (bclk_rise) begin
        fclk_prev <= fclk_s;
        primed    <= 1'b1;
        if (primed) begin
          bit_val <= data_s;
          if (frame_edge) begin
            pos     <= '0;
            half    <= fclk_s;
            locked  <= 1'b1;
            bit_stb <= 1'b1;
          end else begin
            if (pos != '1) pos <= pos + 1'b1;
            bit_stb <= locked;
          end
        end
      end
    end
  end

  // R10: a bit reaches the assembler only after a frame edge was seen
  assert_stb_locked_R10: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> locked);
endmodule

// File: rtl/sar_word_asm.sv
module sar_word_asm
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 8,
  parameter int CHAN_W   = 3,
  parameter int HALF_LEN = 32,
  parameter int SLOTS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt,
  input  logic [1:0]        w_code,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [POS_W-1:0]  pos,
  input  logic              half,
  output logic              out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [CHAN_W-1:0] out_chan
);
  localparam int PK256_SLOT = 32;
  localparam int PK128_SLOT = 16;

  int                  w;
  int                  slot_len;
  int                  p;
  int                  rel;
  int                  slot;
  logic                ok;
  logic                in_win;
  logic                last;
  logic [CHAN_W-1:0]   ch;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] nxt;
  logic [SAMPLE_W-1:0] aligned;

  always_comb begin
    w        = width_of(w_code);
    if (fmt == FMT_PK128) w = WIDTH_16;
    slot_len = (fmt == FMT_PK128) ? PK128_SLOT : PK256_SLOT;
    p        = int'(pos);
    rel      = -1;
    slot     = 0;
    ok       = 1'b1;
    ch       = '0;
    case (fmt)
      FMT_I2S: begin
        rel = p - 1;
        ch  = CHAN_W'(half);
      end
      FMT_LJ: begin
        rel = p;
        ch  = CHAN_W'(half);
      end
      FMT_RJ: begin
        rel = p - (HALF_LEN - w);
        ch  = CHAN_W'(half);
      end
      FMT_DSP: begin
        if (p > w) begin
          rel = p - 1 - w;
          ch  = CHAN_W'(1);
        end else begin
          rel = p - 1;
          ch  = '0;
        end
      end
      FMT_PK256, FMT_PK128: begin
        slot = p / slot_len;
        rel  = p % slot_len;
        ok   = (slot < SLOTS);
        ch   = CHAN_W'(int'(half) * SLOTS + slot);
      end
      default: ;
    endcase
    in_win  = ok && (rel >= 0) && (rel < w);
    last    = in_win && (rel == w - 1);
    nxt     = {shreg[SAMPLE_W-2:0], bit_val};
    aligned = nxt << (SAMPLE_W - w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (bit_stb && in_win) begin
        shreg <= nxt;
        if (last) begin
          out_valid <= 1'b1;
          out_data  <= aligned;
          out_chan  <= ch;
        end
      end
    end
  end

  // R8: bits below the configured width are always zero
  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data << w) == '0));

  // R2: two-channel framings only ever tag channel 0 or 1
  assert_stereo_chan_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fmt != FMT_PK256 && fmt != FMT_PK128) |-> (out_chan < CHAN_W'(2)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int POS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_LEN    = 32,
  parameter int SLOTS       = 4,
  localparam int CHAN_W     = $clog2(2 * SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  input  logic                ser_bclk,
  input  logic                ser_fclk,
  input  logic                ser_data,
  output logic                smp_valid,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic [CHAN_W-1:0]   smp_chan
);
  fmt_e             fmt;
  logic             bclk_rise;
  logic             fclk_s;
  logic             data_s;
  logic             bit_stb;
  logic             bit_val;
  logic [POS_W-1:0] pos;
  logic             half;
  logic             locked;

  assign fmt = decode_fmt(fmt_sel);

  sar_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .bclk_in(ser_bclk), .fclk_in(ser_fclk), .data_in(ser_data),
    .bclk_rise(bclk_rise), .fclk_s(fclk_s), .data_s(data_s)
  );

  sar_frame_track #(.POS_W(POS_W)) u_track (
    .clk(clk), .rst(rst),
    .bclk_rise(bclk_rise), .fclk_s(fclk_s), .data_s(data_s),
    .rise_only(fmt == FMT_DSP),
    .bit_stb(bit_stb), .bit_val(bit_val), .pos(pos), .half(half),
    .locked(locked)
  );

  sar_word_asm #(
    .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .CHAN_W(CHAN_W),
    .HALF_LEN(HALF_LEN), .SLOTS(SLOTS)
  ) u_asm (
    .clk(clk), .rst(rst), .fmt(fmt), .w_code(width_sel),
    .bit_stb(bit_stb), .bit_val(bit_val), .pos(pos), .half(half),
    .out_valid(smp_valid), .out_data(smp_data), .out_chan(smp_chan)
  );

  // R1: outputs are cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!smp_valid && smp_data == '0 && smp_chan == '0));

  // R10: the strobe lasts a single cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R10: nothing is produced before the first frame edge
  assert_no_early_word_R10: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !smp_valid);
endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  width_sel = 2'd0;
  logic        ser_bclk = 1'b0;
  logic        ser_fclk = 1'b0;
  logic        ser_data = 1'b0;
  logic        smp_valid;
  logic [23:0] smp_data;
  logic [2:0]  smp_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [23:0] vals [8];
  logic [23:0] exp_d [16];
  logic [2:0]  exp_c [16];
  logic [23:0] got_d [16];
  logic [2:0]  got_c [16];
  int          got_n = 0;

  always #2.5 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan)
  );

  always @(negedge clk) begin
    if (rst) got_n = 0;
    else if (smp_valid) begin
      if (got_n < 16) begin
        got_d[got_n] = smp_data;
        got_c[got_n] = smp_chan;
      end
      got_n = got_n + 1;
    end
  end

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic send_bit(input logic f, input logic d);
    @(negedge clk);
    ser_bclk = 1'b0; ser_fclk = f; ser_data = d;
    repeat (2) @(negedge clk);
    ser_bclk = 1'b1;
    @(negedge clk);
  endtask

  function automatic string tag_of(input int fc, input int wc);
    string s;
    if (fc >= 6 || wc == 3) return "R9";
    case (fc)
      0: s = "R2";
      1: s = "R4";
      2: s = "R5";
      3: s = "R3";
      4: s = "R6";
      default: s = "R7";
    endcase
    if (wc != 0) s = {s, "+R8"};
    return s;
  endfunction

  task automatic run_cfg(input int fc, input int wc);
    int m, we, sl, nch, rel;
    logic [23:0] mask;
    logic idle_f;
    string tag;
    tag = tag_of(fc, wc);
    m   = (fc >= 6) ? 0 : fc;
    we  = (wc == 1) ? 20 : (wc == 2) ? 16 : 24;
    if (m == 5) we = 16;
    sl  = (m == 5) ? 16 : 32;
    nch = (m >= 4) ? 8 : 2;
    mask = 24'hFFFFFF << (24 - we);
    idle_f = (m == 2) ? 1'b0 : 1'b1;
    @(negedge clk);
    rst = 1'b1; fmt_sel = fc[2:0]; width_sel = wc[1:0];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) send_bit(idle_f, 1'($urandom));
    for (int fr = 0; fr < 2; fr++) begin
      for (int i = 0; i < nch; i++) vals[i] = 24'($urandom);
      if (fr == 0) begin vals[0] = 24'h7FFFFF; vals[1] = 24'h800000; end
      for (int i = 0; i < nch; i++) begin
        exp_d[fr*nch+i] = vals[i] & mask;
        exp_c[fr*nch+i] = 3'(i);
      end
      if (m == 2) begin
        for (int k = 0; k < 64; k++) begin
          logic b;
          b = 1'($urandom);
          if (k >= 1 && k <= we) b = vals[0][24-k];
          else if (k > we && k <= 2*we) b = vals[1][24-(k-we)];
          send_bit(k == 0, b);
        end
      end else begin
        for (int h = 0; h < 2; h++) begin
          int len;
          len = (m >= 4) ? 4*sl : 32;
          for (int k = 0; k < len; k++) begin
            logic b;
            int idx;
            b = 1'($urandom);
            idx = h;
            if (m >= 4) begin rel = k % sl; idx = h*4 + k/sl; end
            else if (m == 0) rel = k - 1;
            else if (m == 3) rel = k;
            else rel = k - (32 - we);
            if (rel >= 0 && rel < we) b = vals[idx][23-rel];
            send_bit(h[0], b);
          end
        end
      end
    end
    for (int i = 0; i < 3; i++) send_bit(idle_f, 1'($urandom));
    repeat (10) @(negedge clk);
    check(got_n == 2*nch, {tag, "+R10"}, $sformatf("word count fmt=%0d w=%0d", fc, wc),
          32'(got_n), 32'(2*nch));
    for (int i = 0; i < 2*nch && i < got_n && i < 16; i++) begin
      check(got_d[i] == exp_d[i], tag, $sformatf("data fmt=%0d w=%0d word %0d", fc, wc, i),
            32'(got_d[i]), 32'(exp_d[i]));
      check(got_c[i] == exp_c[i], {tag, "+R10"}, $sformatf("chan fmt=%0d w=%0d word %0d", fc, wc, i),
            32'(got_c[i]), 32'(exp_c[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(smp_valid == 1'b0, "R1", "valid in reset", 32'(smp_valid), 0);
    check(smp_data == 24'h0, "R1", "data in reset", 32'(smp_data), 0);
    check(smp_chan == 3'h0, "R1", "chan in reset", 32'(smp_chan), 0);
    for (int fc = 0; fc < 8; fc++)
      for (int wc = 0; wc < 4; wc++)
        run_cfg(fc, wc);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule